// File: doc/BRIEF.md
# Dual-Frame Serial Control and Result Port

This block is the slave side of a five-wire serial link on an eight-channel, twelve-bit data converter. The host supplies the shift clock, a data line into the block and two active-low frame strobes: one frames writes, the other frames reads. A write frame loads a six-bit control word. That word selects the input channel, picks the output coding, may request a conversion and may put the converter into standby. A read frame shifts out a sixteen-bit word made of the coding bit, the channel bits and the latest conversion result.

All serial inputs are brought into the system clock domain through synchronizers, and their edges are detected there. The host clock may stop between bytes. The two strobes may be tied together. In that case a single frame returns the finished result and loads the next control word. The control fields go to the conversion sequencer, which returns each new result with a one-cycle valid strobe.

Top module: `adc_serial_port`

## Requirements
- R1: After reset the channel field, the coding bit and the standby bit are 0. The data output enable is 0 and no conversion request is issued.
- R2: While the write strobe is low, each falling shift-clock edge captures one input bit, MSB first. The six bits form, in order: channel[2:0], coding, conversion request, standby. The control outputs change only once the sixth bit has been captured.
- R3: Bits clocked in after the sixth in the same write frame are ignored, and the control outputs keep their values.
- R4: A write frame that ends before its sixth bit leaves the control outputs unchanged, and the next write frame again starts counting from its first bit.
- R5: A completed write whose conversion-request bit is 1 gives exactly one single-cycle pulse on `conv_start`. A completed write with that bit 0 gives no pulse.
- R6: The read word is {coding, channel[2:0], result[11:0]}, sent MSB first. Bit 15 appears on `sdo` when the read frame starts. Each rising shift-clock edge that follows a falling edge inside the frame moves to the next bit.
- R7: `sdo_en` is 1 from the start of the read frame until the sixteenth advancing rising edge, or until the read strobe returns high, whichever comes first. While `sdo_en` is 0, `sdo` is 0.
- R8: The read word is captured when the frame starts. A result strobe arriving later in the frame does not alter the word being sent. A result strobe in the same cycle as the capture puts the new result into the word.
- R9: A pause of the shift clock in either level, for example between the two bytes of a read, neither loses nor repeats a bit.
- R10: With both strobes driven together, the read word carries the coding and channel values from before the frame. The control outputs take the newly written word at the sixth bit.
- R11: The result reported by the next read frame is the last value presented with `res_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Host shift clock |
| rfs_n | input | 1 | Read frame strobe, active low |
| tfs_n | input | 1 | Write frame strobe, active low |
| sdi | input | 1 | Serial data from host |
| res_valid | input | 1 | New result strobe from the sequencer |
| res_data | input | 12 | Conversion result |
| sdo | output | 1 | Serial data to host |
| sdo_en | output | 1 | Output drive enable (0 = high impedance) |
| ctl_addr | output | 3 | Selected channel |
| ctl_fmt | output | 1 | Output coding select |
| ctl_stby | output | 1 | Standby request |
| conv_start | output | 1 | Single-cycle software conversion request |

## Verification
The contested cycle is the one in which a read frame captures its word. The sequencer can deliver a new result in that same cycle. The bench raises `res_valid` exactly in the capture cycle, which it places by counting the synchronizer stages from the strobe's falling edge, and expects the new result in the returned word. It then repeats the case one cycle later and expects the old word, unchanged. A second overlap comes from the tied-strobe frame, where the control word being replaced is also being reported: the bench expects the pre-frame channel and coding bits in the data and the new fields on the control outputs afterwards.

// File: rtl/adc_serial_port.sv
module adc_serial_port #(
  parameter int RES_W       = 12,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              rfs_n,
  input  logic              tfs_n,
  input  logic              sdi,
  input  logic              res_valid,
  input  logic [RES_W-1:0]  res_data,
  output logic              sdo,
  output logic              sdo_en,
  output logic [ADDR_W-1:0] ctl_addr,
  output logic              ctl_fmt,
  output logic              ctl_stby,
  output logic              conv_start
);
  localparam int CTL_W  = ADDR_W + 3;
  localparam int WORD_W = 1 + ADDR_W + RES_W;
  localparam int WCW    = $clog2(CTL_W + 1);
  localparam int RCW    = $clog2(WORD_W + 1);
  localparam logic [WCW-1:0] WC_FULL = WCW'(CTL_W);
  localparam logic [WCW-1:0] WC_LAST = WCW'(CTL_W - 1);
  localparam logic [RCW-1:0] RC_LAST = RCW'(WORD_W - 1);

  logic [SYNC_STAGES:0] sclk_s, rfs_s, tfs_s, sdi_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_s <= '1;
      rfs_s  <= '1;
      tfs_s  <= '1;
      sdi_s  <= '0;
    end else begin
      sclk_s <= {sclk_s[SYNC_STAGES-1:0], sclk};
      rfs_s  <= {rfs_s[SYNC_STAGES-1:0],  rfs_n};
      tfs_s  <= {tfs_s[SYNC_STAGES-1:0],  tfs_n};
      sdi_s  <= {sdi_s[SYNC_STAGES-1:0],  sdi};
    end

  wire sclk_fall = sclk_s[SYNC_STAGES] & ~sclk_s[SYNC_STAGES-1];
  wire sclk_rise = ~sclk_s[SYNC_STAGES] & sclk_s[SYNC_STAGES-1];
  wire rd_act    = ~rfs_s[SYNC_STAGES-1];
  wire rd_start  = rfs_s[SYNC_STAGES] & rd_act;
  wire wr_act    = ~tfs_s[SYNC_STAGES-1];
  wire din       = sdi_s[SYNC_STAGES-1];

  // write side
  logic [WCW-1:0]   wcnt;
  logic [CTL_W-2:0] wsr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wcnt       <= '0;
      wsr        <= '0;
      ctl_addr   <= '0;
      ctl_fmt    <= 1'b0;
      ctl_stby   <= 1'b0;
      conv_start <= 1'b0;
    end else begin
      conv_start <= 1'b0;
      if (!wr_act) begin
        wcnt <= '0;
      end else if (sclk_fall && wcnt < WC_FULL) begin
        wsr  <= {wsr[CTL_W-3:0], din};
        wcnt <= wcnt + 1'b1;
        if (wcnt == WC_LAST) begin
          ctl_addr   <= wsr[CTL_W-2 -: ADDR_W];
          ctl_fmt    <= wsr[1];
          conv_start <= wsr[0];
          ctl_stby   <= din;
        end
      end
    end

  // read side
  logic [RES_W-1:0]  res_q;
  logic [WORD_W-1:0] rsr;
  logic [RCW-1:0]    rcnt;
  logic              pend;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         res_q <= '0;
    else if (res_valid) res_q <= res_data;

  wire [WORD_W-1:0] load_word = {ctl_fmt, ctl_addr, res_valid ? res_data : res_q};
  wire              rd_shift  = rd_act & ~rd_start & sdo_en & sclk_rise & pend;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rsr    <= '0;
      rcnt   <= '0;
      pend   <= 1'b0;
      sdo_en <= 1'b0;
    end else if (!rd_act) begin
      rcnt   <= '0;
      pend   <= 1'b0;
      sdo_en <= 1'b0;
    end else if (rd_start) begin
      rsr    <= load_word;
      rcnt   <= '0;
      pend   <= 1'b0;
      sdo_en <= 1'b1;
    end else if (sdo_en) begin
      if (sclk_fall) begin
        pend <= 1'b1;
      end else if (rd_shift) begin
        pend <= 1'b0;
        rsr  <= {rsr[WORD_W-2:0], 1'b0};
        rcnt <= rcnt + 1'b1;
        if (rcnt == RC_LAST) sdo_en <= 1'b0;
      end
    end

  assign sdo = sdo_en & rsr[WORD_W-1];

endmodule

// File: rtl/adc_serial_port_chk.sv
module adc_serial_port_chk #(
  parameter int CTL_W  = 6,
  parameter int WORD_W = 16,
  parameter int WCW    = 3,
  parameter int RCW    = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              conv_start,
  input logic              sdo_en,
  input logic              sdo,
  input logic [CTL_W-4:0]  ctl_addr,
  input logic              ctl_fmt,
  input logic              ctl_stby,
  input logic [WCW-1:0]    wcnt,
  input logic [RCW-1:0]    rcnt,
  input logic [WORD_W-1:0] rsr,
  input logic              rd_shift
);
  wire [CTL_W-2:0] ctl = {ctl_addr, ctl_fmt, ctl_stby};

  a_r2_update_at_sixth: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctl) |-> (int'(wcnt) == CTL_W));

  a_r3_extra_bits_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(wcnt) == CTL_W && int'($past(wcnt)) == CTL_W) |-> $stable(ctl));

  a_r4_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    int'(wcnt) <= CTL_W);

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  a_r5_pulse_on_complete: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> (int'(wcnt) == CTL_W && int'($past(wcnt)) == CTL_W - 1));

  a_r7_enable_window: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_en |-> int'(rcnt) < WORD_W);

  a_r7_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !sdo_en |-> !sdo);

  a_r8_word_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sdo_en) && sdo_en && !$past(rd_shift)) |-> $stable(rsr));
endmodule

bind adc_serial_port adc_serial_port_chk #(
  .CTL_W(CTL_W), .WORD_W(WORD_W), .WCW(WCW), .RCW(RCW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .sdo_en(sdo_en), .sdo(sdo),
  .ctl_addr(ctl_addr), .ctl_fmt(ctl_fmt), .ctl_stby(ctl_stby),
  .wcnt(wcnt), .rcnt(rcnt), .rsr(rsr), .rd_shift(rd_shift)
);

// File: tb/sim_adc_serial_port.sv
module sim_adc_serial_port;
  localparam int CLK_P = 10;
  localparam int HALF  = 6;

  logic clk = 0, rst_n = 0;
  logic sclk = 1, rfs_n = 1, tfs_n = 1, sdi = 0;
  logic res_valid = 0;
  logic [11:0] res_data = '0;
  logic sdo, sdo_en, ctl_fmt, ctl_stby, conv_start;
  logic [2:0] ctl_addr;

  int tests = 0, fails = 0, conv_cnt = 0;
  bit done = 0;

  logic [2:0]  m_addr = 0;
  logic        m_fmt = 0, m_stby = 0;
  logic [11:0] m_res = 0;

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) if (conv_start) conv_cnt++;

  adc_serial_port u0 (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .rfs_n(rfs_n), .tfs_n(tfs_n), .sdi(sdi),
    .res_valid(res_valid), .res_data(res_data), .sdo(sdo), .sdo_en(sdo_en),
    .ctl_addr(ctl_addr), .ctl_fmt(ctl_fmt), .ctl_stby(ctl_stby), .conv_start(conv_start)
  );

  function automatic logic [15:0] exp_word();
    return {m_fmt, m_addr, m_res};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_cycle(input logic din, output logic dout);
    dout = sdo;
    sdi  = din;
    sclk = 0;
    wait_n(HALF);
    sclk = 1;
    wait_n(HALF);
  endtask

  task automatic put_res(input logic [11:0] v);
    res_data = v; res_valid = 1;
    wait_n(1);
    res_valid = 0;
    m_res = v;
  endtask

  // rd/wr select strobes; wbits MSB-first left-aligned; pause_at inserts a clock stop
  task automatic frame(input bit rd, input bit wr, input logic [15:0] wbits,
                       input int nbits, input int pause_at, output logic [15:0] rbits);
    logic b;
    rbits = '0;
    rfs_n = !rd; tfs_n = !wr;
    wait_n(HALF);
    for (int i = 0; i < nbits; i++) begin
      if (i == pause_at) wait_n(25);
      bit_cycle(wbits[15-i], b);
      rbits[15-i] = b;
    end
  endtask

  task automatic end_frame();
    rfs_n = 1; tfs_n = 1;
    wait_n(HALF);
  endtask

  task automatic write_ctl(input logic [5:0] w, input int nbits, input logic [9:0] junk);
    logic [15:0] r;
    frame(0, 1, {w, junk}, nbits, -1, r);
    end_frame();
    if (nbits >= 6) begin
      m_addr = w[5:3]; m_fmt = w[2]; m_stby = w[0];
    end
  endtask

  task automatic check_ctl(input string tag);
    chk(tag, {27'd0, ctl_addr, ctl_fmt, ctl_stby}, {27'd0, m_addr, m_fmt, m_stby});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    logic [5:0] w;
    int c0, n;
    void'($urandom(32'h1bad5eed));
    wait_n(4);
    rst_n = 1;
    wait_n(2);

    chk("R1 enable after reset", sdo_en, 0);
    check_ctl("R1 control after reset");
    chk("R1 no request after reset", conv_cnt, 0);

    // directed: six-bit write with request
    c0 = conv_cnt;
    write_ctl(6'b101_1_1_0, 6, '0);
    check_ctl("R2 six-bit write");
    chk("R5 request pulse", conv_cnt - c0, 1);

    // extra bits ignored
    c0 = conv_cnt;
    write_ctl(6'b010_0_0_1, 16, 10'h3ff);
    check_ctl("R3 trailing bits ignored");
    chk("R5 no pulse when bit clear", conv_cnt - c0, 0);

    // short frame then a full one
    write_ctl(6'b111_1_1_1, 4, '0);
    check_ctl("R4 short frame no effect");
    chk("R5 no pulse on short frame", conv_cnt - c0, 0);
    write_ctl(6'b001_1_0_0, 6, '0);
    check_ctl("R4 count restarts next frame");

    // read basic
    put_res(12'hA5C);
    frame(1, 0, '0, 16, -1, r);
    chk("R6 read word", r, exp_word());
    chk("R7 enable off after 16 bits", sdo_en, 0);
    chk("R7 output quiet after 16", sdo, 0);
    end_frame();
    chk("R11 result tracked", r[11:0], 12'hA5C);

    // early end of read
    frame(1, 0, '0, 8, -1, r);
    chk("R7 enable still on mid frame", sdo_en, 1);
    chk("R6 first byte", r[15:8], exp_word() >> 8);
    end_frame();
    chk("R7 enable off on strobe high", sdo_en, 0);

    // R8 coincident result strobe in capture cycle
    m_res = 12'h111;
    put_res(12'h111);
    wait_n(2);
    rfs_n = 0;
    wait_n(2);
    res_data = 12'h7E2; res_valid = 1;
    wait_n(1);
    res_valid = 0;
    m_res = 12'h7E2;
    wait_n(HALF);
    for (int i = 0; i < 16; i++) begin
      logic b;
      bit_cycle(1'b0, b);
      r[15-i] = b;
    end
    end_frame();
    chk("R8 same-cycle result captured", r, exp_word());

    // R8 result one cycle after capture stays out
    rfs_n = 0;
    wait_n(3);
    res_data = 12'h0F0; res_valid = 1;
    wait_n(1);
    res_valid = 0;
    wait_n(HALF);
    for (int i = 0; i < 16; i++) begin
      logic b;
      if (i == 5) put_res(12'h3C3);
      bit_cycle(1'b0, b);
      r[15-i] = b;
    end
    end_frame();
    chk("R8 word frozen in frame", r, {m_fmt, m_addr, 12'h7E2});
    frame(1, 0, '0, 16, -1, r);
    end_frame();
    chk("R11 later result reported", r, exp_word());

    // R9 pause between bytes
    frame(1, 0, '0, 16, 8, r);
    end_frame();
    chk("R9 paused read", r, exp_word());

    // R10 tied strobes
    c0 = conv_cnt;
    w = 6'b110_1_1_1;
    frame(1, 1, {w, 10'd0}, 16, -1, r);
    end_frame();
    chk("R10 read shows old control", r, exp_word());
    m_addr = w[5:3]; m_fmt = w[2]; m_stby = w[0];
    check_ctl("R10 control updated");
    chk("R10 request from tied frame", conv_cnt - c0, 1);

    // random mix
    for (int k = 0; k < 40; k++) begin
      int mode = $urandom_range(0, 4);
      w = 6'($urandom);
      c0 = conv_cnt;
      if (mode == 0) begin
        n = $urandom_range(6, 16);
        write_ctl(w, n, 10'($urandom));
        check_ctl("R2 random write");
        chk("R5 random request", conv_cnt - c0, {31'd0, w[1]});
      end else if (mode == 1) begin
        n = $urandom_range(1, 5);
        write_ctl(w, n, 10'($urandom));
        check_ctl("R4 random short write");
      end else if (mode == 2) begin
        put_res(12'($urandom));
        frame(1, 0, '0, 16, $urandom_range(1, 15), r);
        end_frame();
        chk("R9 random paused read", r, exp_word());
      end else if (mode == 3) begin
        put_res(12'($urandom));
        frame(1, 0, '0, 16, -1, r);
        end_frame();
        chk("R6 random read", r, exp_word());
      end else begin
        put_res(12'($urandom));
        frame(1, 1, {w, 10'($urandom)}, 16, -1, r);
        end_frame();
        chk("R10 random tied read", r, exp_word());
        m_addr = w[5:3]; m_fmt = w[2]; m_stby = w[0];
        check_ctl("R10 random tied control");
      end
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule